// File: doc/BRIEF.md
# Twin-Result Single-Precision Add/Subtract Butterfly

This unit accepts two single-precision operands, A and B, and produces both A+B and B−A from one operand fetch, as a radix-2 butterfly stage needs. A single alignment stage is shared by the two results. It compares the operand magnitudes once and shifts the smaller mantissa once. One adder and one subtractor then work on the aligned mantissas, and each result has its own normalize-and-round stage. A one-bit opcode chooses the routing. The add opcode sends the sum to the primary output and the reversed difference to the secondary output. The sub opcode swaps the two.

The block also reports invalid-operation causes (signalling NaN input, infinity minus infinity), overflow, underflow and inexact. For the primary result it gives a class code, a rounded-up bit and an inexact bit. When the record input is set, it also updates a 4-bit condition summary. Subnormal inputs count as zero. Only round-to-nearest-even is built. All outputs are registered and appear one cycle after an accepted input.

Top module: `fp_twin_addsub`

## Requirements
- R1: With op_sub_i=0, pri_o is A+B and sec_o is B−A.
- R2: With op_sub_i=1, pri_o is B−A and sec_o is A+B.
- R3: Finite results are rounded to nearest with ties to even. fr_o=1 when the primary magnitude was rounded up, and fi_o=1 when the primary result is inexact. xx_o is the OR of inexact over both results.
- R4: A NaN input (exponent all ones, fraction nonzero) sets both results to that NaN with fraction bit 22 forced to 1. If A is a NaN its value is used, otherwise B's. vxsnan_o=1 exactly when an input is a signalling NaN (bit 22 clear).
- R5: When both operands are infinite, the result that subtracts like-signed infinities is 0x7FC00000 and vxisi_o=1. The other result is the correctly signed infinity. One infinite operand gives a signed infinity with no flags.
- R6: A rounded result whose exponent reaches 255 becomes a signed infinity and sets ox_o and xx_o.
- R7: A subnormal input acts as a zero of its sign. A result with a biased exponent ≤ 0 before rounding becomes a zero of its sign and sets ux_o and xx_o.
- R8: A difference of equal magnitudes gives +0. A sum of two zeros of the same sign keeps that sign.
- R9: cls_o classifies pri_o: 10001 quiet NaN, 00101 +inf, 01001 −inf, 00100 +normal, 01000 −normal, 00010 +zero, 10010 −zero.
- R10: When in_valid_i and rec_i are both set, cond_o takes {any of vxsnan/vxisi/ox/ux/xx, vxsnan|vxisi, ox, ux} (bit 3 down to bit 0). Otherwise cond_o holds its value.
- R11: out_valid_o is in_valid_i delayed by one cycle. Results and flags update only for an accepted input and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operands valid this cycle |
| op_sub_i | input | 1 | 0: add routing, 1: sub routing |
| rec_i | input | 1 | Update condition summary |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| out_valid_o | output | 1 | Results valid |
| pri_o | output | 32 | Primary result |
| sec_o | output | 32 | Secondary result |
| cls_o | output | 5 | Class code of primary result |
| fr_o | output | 1 | Primary rounded up |
| fi_o | output | 1 | Primary inexact |
| ox_o | output | 1 | Overflow, either result |
| ux_o | output | 1 | Underflow, either result |
| xx_o | output | 1 | Inexact, either result |
| vxsnan_o | output | 1 | Signalling NaN input |
| vxisi_o | output | 1 | Infinity minus infinity |
| cond_o | output | 4 | Condition summary |

## Verification
Every result, flag, class code and the condition summary is due one clock edge after the edge that accepts the operands. out_valid_o rises at that same edge. The bench drives each operation on a falling edge, releases in_valid_i on the next falling edge, and reads all outputs at that moment. That is half a cycle after the registering edge, so every value is settled. Hold behaviour is checked on later falling edges while new operand values are driven with in_valid_i low.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
  localparam int EW   = 8;
  localparam int FW   = 23;
  localparam int DW   = 1 + EW + FW;
  localparam int MW   = FW + 1;
  localparam int GW   = 3;
  localparam int XW   = MW + GW;
  localparam int SW   = XW + 1;
  localparam int NW   = EW + 2;
  localparam int LZW  = $clog2(XW + 1);
  localparam int EMAX = (1 << EW) - 1;
  localparam int QBIT = FW - 1;

  localparam logic [DW-1:0] QNAN_DEF = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

  localparam logic [4:0] CLS_QNAN = 5'b10001;
  localparam logic [4:0] CLS_PINF = 5'b00101;
  localparam logic [4:0] CLS_NINF = 5'b01001;
  localparam logic [4:0] CLS_PNRM = 5'b00100;
  localparam logic [4:0] CLS_NNRM = 5'b01000;
  localparam logic [4:0] CLS_PZER = 5'b00010;
  localparam logic [4:0] CLS_NZER = 5'b10010;

  typedef enum logic {OP_ADD = 1'b0, OP_SUB = 1'b1} op_e;

  typedef struct packed {
    logic          sgn;
    logic [EW-1:0] exp;
    logic [MW-1:0] man;
    logic          zero;
    logic          inf;
    logic          nan;
    logic          snan;
  } opnd_t;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic inx;
    logic inc;
  } rflags_t;
endpackage

// File: rtl/fpb_unpack.sv
module fpb_unpack
  import fpb_pkg::*;
(
  input  logic [DW-1:0] raw_i,
  output opnd_t         op_o
);
  logic [EW-1:0] e;
  logic [FW-1:0] f;
  logic          e_max;

  always_comb begin
    e     = raw_i[DW-2:FW];
    f     = raw_i[FW-1:0];
    e_max = (e == {EW{1'b1}});
    op_o.sgn  = raw_i[DW-1];
    op_o.zero = (e == '0);             // subnormals flushed
    op_o.inf  = e_max && (f == '0);
    op_o.nan  = e_max && (f != '0);
    op_o.snan = e_max && (f != '0) && !f[QBIT];
    op_o.exp  = op_o.zero ? '0 : e;
    op_o.man  = op_o.zero ? '0 : {1'b1, f};
  end
endmodule

// File: rtl/fpb_align.sv
module fpb_align
  import fpb_pkg::*;
(
  input  opnd_t         a_i,
  input  opnd_t         b_i,
  output logic          a_big_o,
  output logic [EW-1:0] exp_o,
  output logic [SW-1:0] sum_o,
  output logic [XW-1:0] dif_o
);
  opnd_t         big, sml;
  logic [EW-1:0] d;
  logic [XW-1:0] base, sh, al, bigx;
  logic          st;

  always_comb begin
    a_big_o = ({a_i.exp, a_i.man} >= {b_i.exp, b_i.man});
    big     = a_big_o ? a_i : b_i;
    sml     = a_big_o ? b_i : a_i;
    d       = big.exp - sml.exp;
    base    = {sml.man, {GW{1'b0}}};
    bigx    = {big.man, {GW{1'b0}}};
    if (d >= EW'(XW)) begin
      sh = '0;
      st = |base;
    end else begin
      sh = base >> d;
      st = |(base & ((XW'(1) << d) - XW'(1)));
    end
    al    = sh | {{(XW-1){1'b0}}, st};
    exp_o = big.exp;
    sum_o = {1'b0, bigx} + {1'b0, al};
    dif_o = bigx - al;   // big >= small in magnitude
  end
endmodule

// File: rtl/fpb_round.sv
module fpb_round
  import fpb_pkg::*;
(
  input  logic          sgn_i,
  input  logic [EW-1:0] exp_i,
  input  logic [SW-1:0] mag_i,
  output logic [DW-1:0] res_o,
  output rflags_t       fl_o
);
  function automatic logic [LZW-1:0] lzc(input logic [XW-1:0] v);
    logic [LZW-1:0] n;
    n = LZW'(XW);
    for (int i = 0; i < XW; i++)
      if (v[i]) n = LZW'(XW - 1 - i);
    return n;
  endfunction

  logic [LZW-1:0]  lz;
  logic [XW-1:0]   m;
  logic signed [NW-1:0] e, e2;
  logic [MW:0]     rm;
  logic            up, inexact;
  logic [FW-1:0]   frac;

  always_comb begin
    lz = lzc(mag_i[XW-1:0]);
    if (mag_i[SW-1]) begin
      m = {mag_i[SW-1:2], |mag_i[1:0]};
      e = $signed({2'b00, exp_i}) + NW'(1);
    end else begin
      m = mag_i[XW-1:0] << lz;
      e = $signed({2'b00, exp_i}) - $signed({{(NW-LZW){1'b0}}, lz});
    end
    inexact = |m[GW-1:0];
    up      = m[GW-1] & (m[GW-2] | m[GW-3] | m[GW]);
    rm      = {1'b0, m[XW-1:GW]} + {{MW{1'b0}}, up};
    if (rm[MW]) begin
      e2   = e + NW'(1);
      frac = '0;
    end else begin
      e2   = e;
      frac = rm[FW-1:0];
    end

    fl_o = '0;
    if (mag_i == '0) begin
      res_o = {sgn_i, {(DW-1){1'b0}}};
    end else if (e <= 0) begin
      res_o    = {sgn_i, {(DW-1){1'b0}}};
      fl_o.unf = 1'b1;
      fl_o.inx = 1'b1;
    end else if (e2 >= $signed(NW'(EMAX))) begin
      res_o    = {sgn_i, {EW{1'b1}}, {FW{1'b0}}};
      fl_o.ovf = 1'b1;
      fl_o.inx = 1'b1;
    end else begin
      res_o    = {sgn_i, e2[EW-1:0], frac};
      fl_o.inx = inexact;
      fl_o.inc = up;
    end
  end
endmodule

// File: rtl/fp_twin_addsub.sv
module fp_twin_addsub
  import fpb_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic          op_sub_i,
  input  logic          rec_i,
  input  logic [31:0]   a_i,
  input  logic [31:0]   b_i,
  output logic          out_valid_o,
  output logic [31:0]   pri_o,
  output logic [31:0]   sec_o,
  output logic [4:0]    cls_o,
  output logic          fr_o,
  output logic          fi_o,
  output logic          ox_o,
  output logic          ux_o,
  output logic          xx_o,
  output logic          vxsnan_o,
  output logic          vxisi_o,
  output logic [3:0]    cond_o
);
  localparam int NR = 2;  // index 0: A+B, index 1: B-A

  logic [DW-1:0] raw [NR];
  opnd_t         op  [NR];
  assign raw[0] = a_i;
  assign raw[1] = b_i;

  for (genvar gi = 0; gi < NR; gi++) begin : g_unp
    fpb_unpack u_unp (.raw_i(raw[gi]), .op_o(op[gi]));
  end

  logic          a_big;
  logic [EW-1:0] big_exp;
  logic [SW-1:0] sum_mag;
  logic [XW-1:0] dif_mag;

  fpb_align u_align (
    .a_i(op[0]), .b_i(op[1]),
    .a_big_o(a_big), .exp_o(big_exp), .sum_o(sum_mag), .dif_o(dif_mag)
  );

  logic          sa, sb;
  logic          eff_add [NR];
  logic          rsgn    [NR];
  logic [SW-1:0] rmag    [NR];
  logic [DW-1:0] rres    [NR];
  rflags_t       rfl     [NR];

  always_comb begin
    sa = op[0].sgn;
    sb = op[1].sgn;
    eff_add[0] = (sa == sb);
    eff_add[1] = (sa != sb);
    rsgn[0] = eff_add[0] ? sa : (a_big ? sa : sb);
    rsgn[1] = eff_add[1] ? sb : (a_big ? ~sa : sb);
    for (int i = 0; i < NR; i++) begin
      rmag[i] = eff_add[i] ? sum_mag : {1'b0, dif_mag};
      if (!eff_add[i] && dif_mag == '0) rsgn[i] = 1'b0;  // exact cancel -> +0
    end
  end

  for (genvar gi = 0; gi < NR; gi++) begin : g_rnd
    fpb_round u_rnd (
      .sgn_i(rsgn[gi]), .exp_i(big_exp), .mag_i(rmag[gi]),
      .res_o(rres[gi]), .fl_o(rfl[gi])
    );
  end

  // special operands
  logic          any_nan, any_snan, any_inf, special;
  logic [DW-1:0] qsel;
  logic          isi   [NR];
  logic          isgn  [NR];
  logic [DW-1:0] res   [NR];
  rflags_t       fl    [NR];

  always_comb begin
    any_nan  = op[0].nan | op[1].nan;
    any_snan = op[0].snan | op[1].snan;
    any_inf  = op[0].inf | op[1].inf;
    special  = any_nan | any_inf;
    qsel     = (op[0].nan ? a_i : b_i) | (DW'(1) << QBIT);
    isi[0]   = op[0].inf & op[1].inf & (sa != sb);
    isi[1]   = op[0].inf & op[1].inf & (sa == sb);
    isgn[0]  = op[0].inf ? sa : sb;
    isgn[1]  = op[0].inf ? ~sa : sb;
    for (int i = 0; i < NR; i++) begin
      fl[i] = special ? '0 : rfl[i];
      if (any_nan)      res[i] = qsel;
      else if (isi[i])  res[i] = QNAN_DEF;
      else if (any_inf) res[i] = {isgn[i], {EW{1'b1}}, {FW{1'b0}}};
      else              res[i] = rres[i];
    end
  end

  function automatic logic [4:0] classify(input logic [DW-1:0] v);
    logic          s;
    logic [EW-1:0] e;
    logic [FW-1:0] f;
    s = v[DW-1];
    e = v[DW-2:FW];
    f = v[FW-1:0];
    if (e == {EW{1'b1}})
      return (f != '0) ? CLS_QNAN : (s ? CLS_NINF : CLS_PINF);
    if (e == '0)
      return s ? CLS_NZER : CLS_PZER;
    return s ? CLS_NNRM : CLS_PNRM;
  endfunction

  op_e           opc;
  logic [DW-1:0] pri_n, sec_n;
  rflags_t       pfl;
  logic          vxs_n, vxi_n, ox_n, ux_n, xx_n;
  logic [3:0]    cond_n;

  always_comb begin
    opc    = op_e'(op_sub_i);
    pri_n  = (opc == OP_SUB) ? res[1] : res[0];
    sec_n  = (opc == OP_SUB) ? res[0] : res[1];
    pfl    = (opc == OP_SUB) ? fl[1]  : fl[0];
    vxs_n  = any_snan;
    vxi_n  = !any_nan & (isi[0] | isi[1]);
    ox_n   = fl[0].ovf | fl[1].ovf;
    ux_n   = fl[0].unf | fl[1].unf;
    xx_n   = fl[0].inx | fl[1].inx;
    cond_n = {vxs_n | vxi_n | ox_n | ux_n | xx_n, vxs_n | vxi_n, ox_n, ux_n};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      pri_o       <= '0;
      sec_o       <= '0;
      cls_o       <= '0;
      fr_o        <= 1'b0;
      fi_o        <= 1'b0;
      ox_o        <= 1'b0;
      ux_o        <= 1'b0;
      xx_o        <= 1'b0;
      vxsnan_o    <= 1'b0;
      vxisi_o     <= 1'b0;
      cond_o      <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        pri_o    <= pri_n;
        sec_o    <= sec_n;
        cls_o    <= classify(pri_n);
        fr_o     <= pfl.inc;
        fi_o     <= pfl.inx;
        ox_o     <= ox_n;
        ux_o     <= ux_n;
        xx_o     <= xx_n;
        vxsnan_o <= vxs_n;
        vxisi_o  <= vxi_n;
        if (rec_i) cond_o <= cond_n;
      end
    end
  end

  a_r11_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(pri_o) && $stable(sec_o) && $stable(cls_o)));
  a_r10_cond_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && rec_i) |=> $stable(cond_o));
  a_r6_ovf_inf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && ox_o) |-> (xx_o && (pri_o[30:23] == 8'hFF || sec_o[30:23] == 8'hFF)));
  a_r7_tiny_inexact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && ux_o) |-> xx_o);
  a_r5_isi_default: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && vxisi_o) |-> (pri_o == 32'h7FC00000 || sec_o == 32'h7FC00000));
  a_r4_snan_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && vxsnan_o) |-> (pri_o[22] && sec_o[22] && pri_o == sec_o));
endmodule

// File: tb/fp_twin_addsub_tb_top.sv
module fp_twin_addsub_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0, op_sub = 1'b0, rec = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        out_valid, fr, fi, ox, ux, xx, vxsnan, vxisi;
  logic [31:0] pri, sec;
  logic [4:0]  cls;
  logic [3:0]  cond;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  fp_twin_addsub dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .op_sub_i(op_sub),
    .rec_i(rec), .a_i(a), .b_i(b), .out_valid_o(out_valid), .pri_o(pri),
    .sec_o(sec), .cls_o(cls), .fr_o(fr), .fi_o(fi), .ox_o(ox), .ux_o(ux),
    .xx_o(xx), .vxsnan_o(vxsnan), .vxisi_o(vxisi), .cond_o(cond)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // flags packed as {vxsnan, vxisi, ox, ux, xx}
  function automatic logic [31:0] flg();
    return {27'd0, vxsnan, vxisi, ox, ux, xx};
  endfunction

  task automatic run(input logic s, input logic r, input logic [31:0] va, input logic [31:0] vb);
    @(negedge clk);
    in_valid = 1'b1; op_sub = s; rec = r; a = va; b = vb;
    @(negedge clk);
    in_valid = 1'b0; rec = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11", "valid", {31'd0, out_valid}, 0);
    chk("R11", "pri", pri, 0);
    chk("R10", "cond", {28'd0, cond}, 0);
  endtask

  task automatic t_add();
    run(0, 0, 32'h3F800000, 32'h40000000);
    chk("R11", "valid", {31'd0, out_valid}, 1);
    chk("R1", "pri", pri, 32'h40400000);
    chk("R1", "sec", sec, 32'h3F800000);
    chk("R9", "cls", {27'd0, cls}, 5'b00100);
    chk("R1", "flags", flg(), 0);
    run(0, 0, 32'h40400000, 32'h3F800000);
    chk("R1", "pri", pri, 32'h40800000);
    chk("R1", "sec", sec, 32'hC0000000);
  endtask

  task automatic t_sub();
    run(1, 0, 32'h3F800000, 32'h40000000);
    chk("R2", "pri", pri, 32'h3F800000);
    chk("R2", "sec", sec, 32'h40400000);
    run(1, 0, 32'h40400000, 32'h3F800000);
    chk("R2", "pri", pri, 32'hC0000000);
    chk("R2", "sec", sec, 32'h40800000);
    chk("R9", "cls", {27'd0, cls}, 5'b01000);
  endtask

  task automatic t_round();
    run(0, 0, 32'h3F800000, 32'h33800000);   // tie, stays even
    chk("R3", "pri", pri, 32'h3F800000);
    chk("R3", "sec", sec, 32'hBF7FFFFF);
    chk("R3", "fr/fi/xx", {29'd0, fr, fi, xx}, 3'b011);
    run(0, 0, 32'h3F800001, 32'h33800000);   // tie, odd goes up
    chk("R3", "pri", pri, 32'h3F800002);
    chk("R3", "sec", sec, 32'hBF800000);
    chk("R3", "fr/fi", {30'd0, fr, fi}, 2'b11);
    run(0, 0, 32'h3F800000, 32'h33C00000);   // above half
    chk("R3", "pri", pri, 32'h3F800001);
    chk("R3", "sec", sec, 32'hBF7FFFFE);
    chk("R3", "fr", {31'd0, fr}, 1);
  endtask

  task automatic t_nan();
    run(0, 1, 32'h7F800001, 32'h3F800000);
    chk("R4", "pri", pri, 32'h7FC00001);
    chk("R4", "sec", sec, 32'h7FC00001);
    chk("R4", "flags", flg(), 5'b10000);
    chk("R9", "cls", {27'd0, cls}, 5'b10001);
    chk("R10", "cond", {28'd0, cond}, 4'b1100);
    run(1, 0, 32'h40000000, 32'hFF800005);
    chk("R4", "pri", pri, 32'hFFC00005);
    chk("R4", "sec", sec, 32'hFFC00005);
    run(0, 0, 32'h7FC12345, 32'h7F800001);
    chk("R4", "pri", pri, 32'h7FC12345);
    chk("R4", "flags", flg(), 5'b10000);
    run(0, 0, 32'h7FC00010, 32'h3F800000);
    chk("R4", "sec", sec, 32'h7FC00010);
    chk("R4", "flags", flg(), 0);
  endtask

  task automatic t_inf();
    run(0, 0, 32'h7F800000, 32'h7F800000);
    chk("R5", "pri", pri, 32'h7F800000);
    chk("R5", "sec", sec, 32'h7FC00000);
    chk("R5", "flags", flg(), 5'b01000);
    chk("R9", "cls", {27'd0, cls}, 5'b00101);
    run(1, 0, 32'h7F800000, 32'hFF800000);
    chk("R5", "pri", pri, 32'hFF800000);
    chk("R5", "sec", sec, 32'h7FC00000);
    chk("R9", "cls", {27'd0, cls}, 5'b01001);
    run(0, 0, 32'h7F800000, 32'h3F800000);
    chk("R5", "sec", sec, 32'hFF800000);
    chk("R5", "flags", flg(), 0);
  endtask

  task automatic t_ovf();
    run(0, 0, 32'h7F7FFFFF, 32'h7F7FFFFF);
    chk("R6", "pri", pri, 32'h7F800000);
    chk("R6", "sec", sec, 32'h00000000);
    chk("R6", "flags", flg(), 5'b00101);
    run(1, 0, 32'hFF7FFFFF, 32'h7F7FFFFF);
    chk("R6", "pri", pri, 32'h7F800000);
    chk("R6", "sec", sec, 32'h00000000);
  endtask

  task automatic t_tiny();
    run(0, 1, 32'h00C00000, 32'h00800000);
    chk("R7", "pri", pri, 32'h01200000);
    chk("R7", "sec", sec, 32'h80000000);
    chk("R7", "flags", flg(), 5'b00011);
    chk("R10", "cond", {28'd0, cond}, 4'b1001);
    run(0, 0, 32'h00000001, 32'h3F800000);
    chk("R7", "pri", pri, 32'h3F800000);
    chk("R7", "sec", sec, 32'h3F800000);
    chk("R7", "flags", flg(), 0);
    run(0, 0, 32'h00000005, 32'h80000003);
    chk("R7", "pri", pri, 32'h00000000);
    chk("R7", "sec", sec, 32'h80000000);
  endtask

  task automatic t_zero();
    run(0, 0, 32'h80000000, 32'h80000000);
    chk("R8", "pri", pri, 32'h80000000);
    chk("R8", "sec", sec, 32'h00000000);
    chk("R9", "cls", {27'd0, cls}, 5'b10010);
    run(0, 0, 32'h40000000, 32'h40000000);
    chk("R8", "sec", sec, 32'h00000000);
    chk("R9", "cls", {27'd0, cls}, 5'b00100);
    run(1, 0, 32'h40000000, 32'h40000000);
    chk("R9", "cls", {27'd0, cls}, 5'b00010);
  endtask

  task automatic t_cond();
    run(0, 0, 32'h7F800001, 32'h3F800000);   // exceptions, no record
    chk("R10", "cond", {28'd0, cond}, 4'b1001);
    run(0, 1, 32'h3F800000, 32'h40000000);
    chk("R10", "cond", {28'd0, cond}, 4'b0000);
  endtask

  task automatic t_hold();
    run(0, 0, 32'h3F800000, 32'h40000000);
    for (int i = 0; i < 3; i++) begin
      a = 32'h7F800000; b = 32'hC0000000; op_sub = 1'b1;
      @(negedge clk);
      chk("R11", "valid", {31'd0, out_valid}, 0);
      chk("R11", "pri", pri, 32'h40400000);
      chk("R11", "sec", sec, 32'h3F800000);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_add();
    t_sub();
    t_round();
    t_nan();
    t_inf();
    t_ovf();
    t_tiny();
    t_zero();
    t_cond();
    t_hold();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule